// File: doc/BRIEF.md
# Three-Bank GPIO Controller with Pin Interrupts

This block provides 96 general-purpose pins, organised as three banks of 32, behind one 32-bit register bus. Software sets each pin's direction, drives outputs either with a whole-word write or with bitwise set and clear writes, and reads back a data word. For an output pin the data word shows the driven value. For an input pin it shows the synchronized pin level. Every pin input passes through a two-flop synchronizer before any logic uses it.

Each pin has four independent trigger enables: rising edge, falling edge, high level and low level. A polarity bit can invert the sampled input before these triggers are evaluated. A trigger that fires sets a sticky status bit, which software clears by writing 1 to it. A single interrupt line is active while any status bit in any bank is set. A read-only edge word reports which pins changed level in the previous sample.

Registers are grouped by function. The group index is address bits [7:4]. The bank index is address bits [3:2], which gives a 4-byte stride between banks inside a group.

Top module: `gpb_ctrl`

## Requirements
- R1: After reset every register reads 0, `pin_out` and `pin_oe` are all 0, and `irq` is 0.
- R2: A register is addressed as group base + bank × 4, with group bases direction 0x00, polarity 0x10, data 0x20, set 0x30, clear 0x40, rising 0x50, falling 0x60, high 0x70, low 0x80, status 0x90, edge 0xA0. The following read 0 and ignore writes: the set and clear groups on read, bank index 3, groups above 0xA, and addresses with bits [1:0] not zero.
- R3: A 1 in a bank's direction word makes the matching `pin_oe` bit 1. A data read returns the output latch for output pins and the synchronized input for input pins.
- R4: A data write loads the output latch. A set write forces latch bits to 1 wherever the written value has a 1. A clear write forces latch bits to 0 wherever the written value has a 1. Bits written as 0 keep their value. `pin_out` shows the latch for every pin, whatever its direction.
- R5: A change on `pin_in` appears in a data read two clock edges later.
- R6: A polarity bit of 1 inverts that pin's sampled input before edge and level detection. Changing the polarity bit therefore counts as a change of level.
- R7: An enabled rising or falling edge sets the status bit one edge after the synchronized level changes. With both edge enables set, either direction triggers. A change on a pin with no enables sets no status bit.
- R8: An enabled high or low level sets the status bit on every cycle the level is present.
- R9: Writing 1 to a status bit clears only that bit. A trigger in the same cycle as the clear wins, so a held level sets the bit again at once. Status bits are sticky until cleared.
- R10: `irq` is 1 exactly when some status bit in some bank is 1.
- R11: The edge word shows, for one cycle, each pin whose polarity-adjusted level changed. The edge word ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read strobe |
| pin_in | input | 96 | Asynchronous pin inputs, global pin n at bit n |
| pin_out | output | 96 | Output latch |
| pin_oe | output | 96 | Output enable, equal to the direction words |
| irq | output | 1 | Combined interrupt |

## Verification
The bench holds its level trigger active and clears the status bit during it. A design in which the clear beats the trigger would read 0 there instead of the re-set bit. Partial status clears and bitwise set/clear writes catch a decoder that clears or overwrites the whole word. Reads taken one and two edges after a pin change expose a synchronizer that is too short or too long. Reads of bank slot 3, of the set and clear groups, and of a write to the read-only edge word show aliasing or a stray write path as nonzero data or a changed register.

// File: rtl/gpb_pkg.sv
package gpb_pkg;
  localparam int ADDR_W = 8;

  typedef enum logic [3:0] {
    GRP_DIR  = 4'd0,
    GRP_POL  = 4'd1,
    GRP_DATA = 4'd2,
    GRP_SET  = 4'd3,
    GRP_CLR  = 4'd4,
    GRP_RISE = 4'd5,
    GRP_FALL = 4'd6,
    GRP_HIGH = 4'd7,
    GRP_LOW  = 4'd8,
    GRP_STAT = 4'd9,
    GRP_EDGE = 4'd10
  } grp_e;
endpackage

// File: rtl/gpb_rst_sync.sv
module gpb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_q <= '0;
    else           chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = chain_q[STAGES-1];
endmodule

// File: rtl/gpb_sync.sv
module gpb_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st_q[i] <= '0;
    end else begin
      st_q[0] <= d;
      for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
    end
  end

  assign q = st_q[STAGES-1];
endmodule

// File: rtl/gpb_bank.sv
module gpb_bank import gpb_pkg::*; #(
  parameter int BW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  grp_e          grp,
  input  logic [BW-1:0] wdata,
  input  logic [BW-1:0] pin_raw,
  output logic [BW-1:0] rdata,
  output logic [BW-1:0] dout_o,
  output logic [BW-1:0] dir_o,
  output logic [BW-1:0] stat_o
);
  logic [BW-1:0] pin_s;
  logic [BW-1:0] dir_q, pol_q, dout_q, rise_q, fall_q, high_q, low_q, stat_q, edge_q, lvl_d_q;
  logic [BW-1:0] dir_n, pol_n, dout_n, rise_n, fall_n, high_n, low_n, stat_n, edge_n;
  logic [BW-1:0] lvl, ev_rise, ev_fall, trig, clr_mask;
  logic dir_we, pol_we, data_we, set_we, clr_we, rise_we, fall_we, high_we, low_we, stat_we;

  gpb_sync #(.W(BW), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_raw), .q(pin_s)
  );

  assign dir_we  = wr_en && (grp == GRP_DIR);
  assign pol_we  = wr_en && (grp == GRP_POL);
  assign data_we = wr_en && (grp == GRP_DATA);
  assign set_we  = wr_en && (grp == GRP_SET);
  assign clr_we  = wr_en && (grp == GRP_CLR);
  assign rise_we = wr_en && (grp == GRP_RISE);
  assign fall_we = wr_en && (grp == GRP_FALL);
  assign high_we = wr_en && (grp == GRP_HIGH);
  assign low_we  = wr_en && (grp == GRP_LOW);
  assign stat_we = wr_en && (grp == GRP_STAT);

  // detection path
  assign lvl      = pin_s ^ pol_q;
  assign ev_rise  = lvl & ~lvl_d_q;
  assign ev_fall  = ~lvl & lvl_d_q;
  assign trig     = (ev_rise & rise_q) | (ev_fall & fall_q) | (lvl & high_q) | (~lvl & low_q);
  assign clr_mask = stat_we ? wdata : '0;

  always_comb begin
    dir_n  = dir_we  ? wdata : dir_q;
    pol_n  = pol_we  ? wdata : pol_q;
    rise_n = rise_we ? wdata : rise_q;
    fall_n = fall_we ? wdata : fall_q;
    high_n = high_we ? wdata : high_q;
    low_n  = low_we  ? wdata : low_q;
    dout_n = dout_q;
    if (data_we)     dout_n = wdata;
    else if (set_we) dout_n = dout_q | wdata;
    else if (clr_we) dout_n = dout_q & ~wdata;
    stat_n = (stat_q & ~clr_mask) | trig;   // a fresh trigger beats the clear
    edge_n = lvl ^ lvl_d_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      pol_q   <= '0;
      dout_q  <= '0;
      rise_q  <= '0;
      fall_q  <= '0;
      high_q  <= '0;
      low_q   <= '0;
      stat_q  <= '0;
      edge_q  <= '0;
      lvl_d_q <= '0;
    end else begin
      dir_q   <= dir_n;
      pol_q   <= pol_n;
      dout_q  <= dout_n;
      rise_q  <= rise_n;
      fall_q  <= fall_n;
      high_q  <= high_n;
      low_q   <= low_n;
      stat_q  <= stat_n;
      edge_q  <= edge_n;
      lvl_d_q <= lvl;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (grp)
        GRP_DIR:  rdata = dir_q;
        GRP_POL:  rdata = pol_q;
        GRP_DATA: rdata = (dir_q & dout_q) | (~dir_q & pin_s);
        GRP_RISE: rdata = rise_q;
        GRP_FALL: rdata = fall_q;
        GRP_HIGH: rdata = high_q;
        GRP_LOW:  rdata = low_q;
        GRP_STAT: rdata = stat_q;
        GRP_EDGE: rdata = edge_q;
        default:  rdata = '0;
      endcase
    end
  end

  assign dout_o = dout_q;
  assign dir_o  = dir_q;
  assign stat_o = stat_q;
endmodule

// File: rtl/gpb_ctrl.sv
module gpb_ctrl import gpb_pkg::*; #(
  parameter int NBANK = 3,
  parameter int BW    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [BW-1:0]       bus_wdata,
  output logic [BW-1:0]       bus_rdata,
  input  logic [NBANK*BW-1:0] pin_in,
  output logic [NBANK*BW-1:0] pin_out,
  output logic [NBANK*BW-1:0] pin_oe,
  output logic                irq
);
  localparam int NPIN   = NBANK * BW;
  localparam int BIDX_W = 2;

  logic              rst_sn;
  logic              aligned;
  grp_e              grp;
  logic [BIDX_W-1:0] bidx;
  logic [BW-1:0]     rd_arr [NBANK];
  logic [NPIN-1:0]   stat_all;

  gpb_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_sn)
  );

  assign aligned = (bus_addr[1:0] == 2'b00);
  assign grp     = grp_e'(bus_addr[7:4]);
  assign bidx    = bus_addr[3:2];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic hit;
    assign hit = bus_sel && aligned && (bidx == BIDX_W'(b));

    gpb_bank #(.BW(BW)) u_bank (
      .clk    (clk),
      .rst_n  (rst_sn),
      .wr_en  (hit && bus_wr),
      .rd_en  (hit && !bus_wr),
      .grp    (grp),
      .wdata  (bus_wdata),
      .pin_raw(pin_in[b*BW +: BW]),
      .rdata  (rd_arr[b]),
      .dout_o (pin_out[b*BW +: BW]),
      .dir_o  (pin_oe[b*BW +: BW]),
      .stat_o (stat_all[b*BW +: BW])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < NBANK; b++) bus_rdata = bus_rdata | rd_arr[b];
  end

  assign irq = |stat_all;
endmodule

// File: rtl/gpb_ctrl_chk.sv
module gpb_ctrl_chk #(
  parameter int NPIN = 96,
  parameter int BW   = 32
) (
  input logic            clk,
  input logic            rst_sn,
  input logic            bus_sel,
  input logic            bus_wr,
  input logic [7:0]      bus_addr,
  input logic [BW-1:0]   bus_wdata,
  input logic [BW-1:0]   bus_rdata,
  input logic [NPIN-1:0] pin_out,
  input logic [NPIN-1:0] pin_oe,
  input logic [NPIN-1:0] stat_all
);
  logic wr0_set, wr0_clr, wr0_dir, wr0_stat, rd_void;
  assign wr0_set  = bus_sel && bus_wr && (bus_addr == 8'h30);
  assign wr0_clr  = bus_sel && bus_wr && (bus_addr == 8'h40);
  assign wr0_dir  = bus_sel && bus_wr && (bus_addr == 8'h00);
  assign wr0_stat = bus_sel && bus_wr && (bus_addr == 8'h90);
  assign rd_void  = bus_sel && !bus_wr && (bus_addr >= 8'hB0);

  // R4: set write drives selected bits high
  a_r4_set_bits: assert property (@(posedge clk) disable iff (!rst_sn)
    wr0_set |=> ((pin_out[BW-1:0] & $past(bus_wdata)) == $past(bus_wdata)));

  // R4: clear write drives selected bits low
  a_r4_clr_bits: assert property (@(posedge clk) disable iff (!rst_sn)
    wr0_clr |=> ((pin_out[BW-1:0] & $past(bus_wdata)) == '0));

  // R3: output enables move only on a direction write
  a_r3_oe_hold: assert property (@(posedge clk) disable iff (!rst_sn)
    !wr0_dir |=> $stable(pin_oe[BW-1:0]));

  // R9: without a status write, set bits stay set
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_sn)
    !wr0_stat |=> ((stat_all[BW-1:0] & $past(stat_all[BW-1:0])) == $past(stat_all[BW-1:0])));

  // R2: groups above the edge word read as zero
  a_r2_void_read: assert property (@(posedge clk) disable iff (!rst_sn)
    rd_void |-> (bus_rdata == '0));
endmodule

bind gpb_ctrl gpb_ctrl_chk #(.NPIN(NPIN), .BW(BW)) u_chk (
  .clk      (clk),
  .rst_sn   (rst_sn),
  .bus_sel  (bus_sel),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .pin_out  (pin_out),
  .pin_oe   (pin_oe),
  .stat_all (stat_all)
);

// File: tb/test_gpb_ctrl.sv
`timescale 1ns/1ps
module test_gpb_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [95:0] pin_in, pin_out, pin_oe;
  logic        irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit started = 1'b0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  gpb_ctrl i_gpb_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // behavioural reference state, one entry per bank
  logic [31:0] m_dir[3], m_pol[3], m_dout[3], m_rise[3], m_fall[3];
  logic [31:0] m_high[3], m_low[3], m_stat[3], m_edge[3];
  logic [31:0] m_s1[3], m_s2[3], m_prev[3];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < 3; b++) begin
        m_dir[b] <= 0; m_pol[b] <= 0; m_dout[b] <= 0; m_rise[b] <= 0;
        m_fall[b] <= 0; m_high[b] <= 0; m_low[b] <= 0; m_stat[b] <= 0;
        m_edge[b] <= 0; m_s1[b] <= 0; m_s2[b] <= 0; m_prev[b] <= 0;
      end
    end else begin
      for (int b = 0; b < 3; b++) begin
        logic [31:0] cur, hit, wipe;
        bit we;
        int g;
        cur = m_s2[b] ^ m_pol[b];
        hit = 0;
        for (int i = 0; i < 32; i++) begin
          if (m_rise[b][i] && cur[i] && !m_prev[b][i]) hit[i] = 1'b1;
          if (m_fall[b][i] && !cur[i] && m_prev[b][i]) hit[i] = 1'b1;
          if (m_high[b][i] && cur[i])  hit[i] = 1'b1;
          if (m_low[b][i]  && !cur[i]) hit[i] = 1'b1;
        end
        we = bus_sel && bus_wr && (bus_addr[1:0] == 0) && (int'(bus_addr[3:2]) == b);
        g  = int'(bus_addr[7:4]);
        wipe = (we && g == 9) ? bus_wdata : 32'h0;
        m_stat[b] <= (m_stat[b] & ~wipe) | hit;
        m_edge[b] <= cur ^ m_prev[b];
        m_prev[b] <= cur;
        m_s2[b]   <= m_s1[b];
        m_s1[b]   <= pin_in[b*32 +: 32];
        if (we) begin
          case (g)
            0: m_dir[b]  <= bus_wdata;
            1: m_pol[b]  <= bus_wdata;
            2: m_dout[b] <= bus_wdata;
            3: m_dout[b] <= m_dout[b] | bus_wdata;
            4: m_dout[b] <= m_dout[b] & ~bus_wdata;
            5: m_rise[b] <= bus_wdata;
            6: m_fall[b] <= bus_wdata;
            7: m_high[b] <= bus_wdata;
            8: m_low[b]  <= bus_wdata;
            default: ;
          endcase
        end
      end
    end
  end

  function automatic logic [31:0] m_read(input logic [7:0] a);
    int g = int'(a[7:4]);
    int b = int'(a[3:2]);
    if (a[1:0] != 0 || b >= 3) return 32'h0;
    case (g)
      0: return m_dir[b];
      1: return m_pol[b];
      2: return (m_dir[b] & m_dout[b]) | (~m_dir[b] & m_s2[b]);
      5: return m_rise[b];
      6: return m_fall[b];
      7: return m_high[b];
      8: return m_low[b];
      9: return m_stat[b];
      10: return m_edge[b];
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the reference, sampled 2 ns after the edge
  always begin
    @(posedge clk);
    #2;
    if (started && !done) begin
      logic [95:0] e_out, e_oe;
      bit e_irq;
      e_out = {m_dout[2], m_dout[1], m_dout[0]};
      e_oe  = {m_dir[2], m_dir[1], m_dir[0]};
      e_irq = (m_stat[0] | m_stat[1] | m_stat[2]) != 0;
      chk(pin_out === e_out, "R4 cycle pin_out", pin_out, e_out);
      chk(pin_oe === e_oe, "R3 cycle pin_oe", pin_oe, e_oe);
      chk(irq === e_irq, "R10 cycle irq", 96'(irq), 96'(e_irq));
      if (bus_sel && !bus_wr)
        chk(bus_rdata === m_read(bus_addr), "R2 cycle rdata", 96'(bus_rdata), 96'(m_read(bus_addr)));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1;
    chk(bus_rdata === exp, req, 96'(bus_rdata), 96'(exp));
    chk(bus_rdata === m_read(a), req, 96'(bus_rdata), 96'(m_read(a)));
  endtask

  task automatic setpin(input int n, input logic v);
    @(negedge clk);
    bus_sel = 0;
    pin_in[n] = v;
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0; pin_in = '0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    idle(4);
    started = 1'b1;

    // R1: everything zero after reset
    for (int g = 0; g <= 10; g++)
      for (int b = 0; b < 3; b++)
        rd(8'((g << 4) | (b << 2)), 32'h0, "R1 reset read");
    chk(pin_out === '0 && pin_oe === '0 && irq === 1'b0, "R1 reset outputs", {pin_out[31:0], pin_oe[31:0], 31'h0, irq}, '0);

    // R3: direction
    wr(8'h04, 32'hFFFF_0000);
    rd(8'h04, 32'hFFFF_0000, "R3 direction readback");
    chk(pin_oe[63:32] === 32'hFFFF_0000, "R3 pin_oe bank1", 96'(pin_oe[63:32]), 96'(32'hFFFF_0000));

    // R4: set, clear and full data writes
    wr(8'h34, 32'h00F0_00F0);
    chk(pin_out[63:32] === 32'h00F0_00F0, "R4 set write", 96'(pin_out[63:32]), 96'(32'h00F0_00F0));
    rd(8'h24, 32'h00F0_0000, "R3 data read mixes latch and inputs");
    wr(8'h44, 32'h0030_0010);
    chk(pin_out[63:32] === 32'h00C0_00E0, "R4 clear write", 96'(pin_out[63:32]), 96'(32'h00C0_00E0));
    wr(8'h24, 32'h1234_5678);
    rd(8'h24, 32'h1234_0000, "R4 data write");

    // R5: two-edge synchronizer latency
    setpin(35, 1'b1);
    rd(8'h24, 32'h1234_0000, "R5 one edge after change");
    rd(8'h24, 32'h1234_0008, "R5 two edges after change");

    // R7: edges on bank0 bits 0..3 (rise on 0,1,3; fall on 2,3)
    wr(8'h50, 32'h0000_000B);
    wr(8'h60, 32'h0000_000C);
    @(negedge clk); pin_in[3:0] = 4'hF;
    idle(1);
    rd(8'h90, 32'h0, "R7 no status before edge is seen");
    rd(8'h90, 32'h0000_000B, "R7 rising status");
    wr(8'h90, 32'h0000_000F);
    rd(8'h90, 32'h0, "R9 full clear");
    @(negedge clk); pin_in[3:0] = 4'h0;
    idle(2);
    rd(8'h90, 32'h0000_000C, "R7 falling and either-edge status");
    chk(irq === 1'b1, "R10 irq with status", 96'(irq), 96'(1));

    // R9: per-bit clear
    wr(8'h90, 32'h0000_0004);
    rd(8'h90, 32'h0000_0008, "R9 single bit cleared");
    wr(8'h90, 32'h0000_0008);
    rd(8'h90, 32'h0, "R9 last bit cleared");
    chk(irq === 1'b0, "R10 irq low when clear", 96'(irq), 96'(0));

    // R11: edge word, and R7 no enables gives no status
    setpin(5, 1'b1);
    idle(2);
    rd(8'hA0, 32'h0000_0020, "R11 edge captured");
    rd(8'hA0, 32'h0, "R11 edge lasts one cycle");
    rd(8'h90, 32'h0, "R7 change without enable ignored");
    wr(8'hA0, 32'hFFFF_FFFF);
    rd(8'hA0, 32'h0, "R11 edge ignores writes");

    // R8: level high on bank2 bit5 (pin 69) and set-wins against clear
    setpin(69, 1'b1);
    idle(3);
    wr(8'h78, 32'h0000_0020);
    rd(8'h98, 32'h0000_0020, "R8 level sets status");
    wr(8'h98, 32'h0000_0020);
    rd(8'h98, 32'h0000_0020, "R9 held level beats clear");
    chk(irq === 1'b1, "R10 irq from bank2", 96'(irq), 96'(1));
    setpin(69, 1'b0);
    idle(3);
    wr(8'h98, 32'h0000_0020);
    rd(8'h98, 32'h0, "R8 released level clears");
    chk(irq === 1'b0, "R10 irq released", 96'(irq), 96'(0));

    // R6: polarity on bank1 bit1 (pin 33)
    wr(8'h74, 32'h0000_0002);
    rd(8'h94, 32'h0, "R6 low pin, no inversion, no trigger");
    wr(8'h14, 32'h0000_0002);
    rd(8'h94, 32'h0000_0002, "R6 inverted level triggers");
    wr(8'h74, 32'h0);
    wr(8'h94, 32'h0000_0002);
    rd(8'h94, 32'h0, "R6 cleared");
    wr(8'h64, 32'h0000_0002);
    setpin(33, 1'b1);
    idle(2);
    rd(8'h94, 32'h0000_0002, "R6 rising pin seen as falling");

    // R2: holes and aliasing
    rd(8'h0C, 32'h0, "R2 bank slot 3");
    rd(8'h30, 32'h0, "R2 set group reads 0");
    rd(8'h44, 32'h0, "R2 clear group reads 0");
    rd(8'hB0, 32'h0, "R2 group above edge");
    rd(8'hF8, 32'h0, "R2 top of map");
    rd(8'h05, 32'h0, "R2 misaligned read");
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h01, 32'hFFFF_FFFF);
    rd(8'h00, 32'h0, "R2 bank0 direction untouched");
    rd(8'h04, 32'hFFFF_0000, "R2 bank1 direction untouched");
    rd(8'h08, 32'h0, "R2 bank2 direction untouched");

    idle(3);
    finish_run();
  end
endmodule